// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block generates up to two pulse-width-modulated outputs from one source clock, the same clock that runs its register port. Each channel divides the clock by a value picked through a four-bit code, counts that divided clock through a programmable period, and drives its pin at an active level while the count is below a programmed duty value. The active level of each pin can be chosen. A per-channel bypass bit routes the clock itself to the pin instead.

Software programs the block through a plain word-addressed register port with byte strobes. One shared control word holds the settings of both channels, placed 15 bits apart. Each channel also has its own period/duty word. A new period/duty value is held back until the running period ends, so that no period is cut short. A read-only ready bit in the control word shows whether that value has been taken yet. The register port is control traffic rather than a data stream, so it has no valid/ready handshake: a write is taken on every clock edge at which `wr_en` is high. Reads are combinational from the address.

Top module: `pwm2_ctrl`

## Requirements
- R1: Byte address 0x0 reads the control word, and 0x4 + 4*n reads the period/duty word last written for channel n. Any other word, and any address whose two low bits are not zero, reads 0; writes to such addresses change nothing. Control bits outside the fields of R2 and R8 read 0.
- R2: The 10-bit field of channel n sits at bit 15*n of the control word, with the prescaler code in [3:0], enable in [4], active-high select in [5], clock-run in [6], two stored spare bits in [7] and [8], and bypass in [9]. Only the bytes whose strobe is set are written, so a write that strobes only bytes 2 and 3 leaves channel 0's field unchanged.
- R3: Prescaler codes 0..4 divide by 120, 180, 240, 360 and 480. Codes 8..12 divide by 12000, 24000, 36000, 48000 and 72000. Code 15 divides by 1. Codes 5, 6, 7, 13 and 14 are invalid and keep the channel stopped.
- R4: While a channel runs, each step of its period counter lasts exactly the divisor's number of clock cycles. A period is P+1 steps, where P is bits [31:16] of its period/duty word.
- R5: Within a period, the channel is active while the step index is below the duty D (bits [15:0]) and inactive for the rest. D = 0 gives a constantly inactive pin, and D > P gives a constantly active pin.
- R6: With bit 5 set, the active level is 1 and the inactive level is 0; with bit 5 clear, the two levels are swapped.
- R7: A channel runs only when enable (bit 4) and clock-run (bit 6) are both 1 and its code is valid. Otherwise its pin holds the inactive level, and its counters restart from step 0 once it runs again.
- R8: A write to a period/duty word is taken at the end of the running period, or on the next clock while the channel is stopped. Control bit 28+n reads 0 from the cycle after that write until the value has been taken, and reads 1 otherwise.
- R9: With bypass (bit 9) set, the pin follows the clock, whatever the other bits of that channel say.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock for the registers and counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write the addressed word on this edge |
| addr | input | ADDR_W | Byte address for both reads and writes |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte enables for the write |
| rdata | output | 32 | Read data for `addr` |
| pwm_o | output | NCH | One pulse-width-modulated output per channel |

## Verification
A wrong prescaler count shows at a pin as a step that is longer or shorter than the divisor. This is visible on the very first edge of that step, at most one divided tick after the fault. A wrong period counter or a value loaded at the wrong time moves the edge of the active phase. This shows within one period, and the ready bit in the control word can give it away even sooner. Because every pin and the read data are compared on every clock against a model that counts cycles since the start of the period, any of these faults is caught on the first cycle in which it changes a visible level.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

  localparam int FIELD_STRIDE = 15;
  localparam int RDY_BASE     = 28;
  localparam int PS_W         = 17;

  typedef struct packed {
    logic       bypass;
    logic       spare_b;
    logic       spare_a;
    logic       clk_run;
    logic       act_high;
    logic       en;
    logic [3:0] code;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);

  function automatic logic [PS_W-1:0] code_to_div(input logic [3:0] code);
    case (code)
      4'd0:    return PS_W'(120);
      4'd1:    return PS_W'(180);
      4'd2:    return PS_W'(240);
      4'd3:    return PS_W'(360);
      4'd4:    return PS_W'(480);
      4'd8:    return PS_W'(12000);
      4'd9:    return PS_W'(24000);
      4'd10:   return PS_W'(36000);
      4'd11:   return PS_W'(48000);
      4'd12:   return PS_W'(72000);
      4'd15:   return PS_W'(1);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler #(
  parameter int PS_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] div,
  output logic            tick
);

  logic [PS_W-1:0] cnt;
  logic [PS_W-1:0] last;

  assign last = div - PS_W'(1);
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + PS_W'(1);
  end

  // R4: with a divisor above one, a tick is followed by at least one quiet cycle
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > PS_W'(1)) |=> (!tick || div <= PS_W'(1)));

endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         code,
  input  logic               en,
  input  logic               clk_run,
  input  logic               act_high,
  input  logic               bypass,
  input  logic               wr_prd,
  input  logic [2*CNT_W-1:0] wdata,
  input  logic [2*CNT_W-1:0] wmask,
  output logic               pwm_o,
  output logic               ready_o,
  output logic [2*CNT_W-1:0] shadow_o
);

  localparam int REG_W = 2 * CNT_W;

  logic [PS_W-1:0]  div;
  logic             run, tick, wrap, load, on;
  logic [CNT_W-1:0] step, prd_act, duty_act;
  logic [REG_W-1:0] shadow;
  logic             pending;

  assign div  = code_to_div(code);
  assign run  = en && clk_run && (div != '0);

  pwm2_prescaler #(.PS_W(PS_W)) presc_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (div),
    .tick (tick)
  );

  assign wrap = tick && (step == prd_act);
  assign load = pending && (!run || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step <= '0;
    else if (!run)   step <= '0;
    else if (wrap)   step <= '0;
    else if (tick)   step <= step + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= '0;
      pending  <= 1'b0;
      prd_act  <= '0;
      duty_act <= '0;
    end else begin
      if (load) begin
        prd_act  <= shadow[REG_W-1:CNT_W];
        duty_act <= shadow[CNT_W-1:0];
        pending  <= 1'b0;
      end
      if (wr_prd) begin
        shadow  <= (shadow & ~wmask) | (wdata & wmask);
        pending <= 1'b1;
      end
    end
  end

  assign on       = run && (step < duty_act);
  assign pwm_o    = bypass ? clk : (act_high ? on : !on);
  assign ready_o  = !pending;
  assign shadow_o = shadow;

  // R5: the step counter never runs past the loaded period
  a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step <= prd_act);

  // R8: a running channel keeps its loaded values until its period ends
  a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(prd_act) && $stable(duty_act)));

  // R8: a write always leaves the ready flag low on the next cycle
  a_r8_write_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prd |=> !ready_o);

  // R7: a stopped channel outside bypass holds its inactive level
  a_r7_stopped_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !run) |-> (pwm_o == !act_high));

endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_o
);

  localparam int DATA_W = 32;
  localparam int CNT_W  = DATA_W / 2;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic [DATA_W-1:0] wmask;
  chan_ctrl_t        ctrl_q [NCH];
  logic [NCH-1:0]    ready;
  logic [DATA_W-1:0] shadow [NCH];

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    for (int b = 0; b < 4; b++) wmask[8*b +: 8] = {8{wstrb[b]}};
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CTRL_W-1:0] fmask;
    logic              wr_ctrl, wr_prd;

    assign fmask   = wmask[FIELD_STRIDE*ch +: CTRL_W];
    assign wr_ctrl = wr_en && aligned && (word == '0);
    assign wr_prd  = wr_en && aligned && (word == WORD_W'(ch + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q[ch] <= '0;
      else if (wr_ctrl) ctrl_q[ch] <= (ctrl_q[ch] & ~fmask) |
                                      (wdata[FIELD_STRIDE*ch +: CTRL_W] & fmask);
    end

    pwm2_channel #(.CNT_W(CNT_W)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (ctrl_q[ch].code),
      .en      (ctrl_q[ch].en),
      .clk_run (ctrl_q[ch].clk_run),
      .act_high(ctrl_q[ch].act_high),
      .bypass  (ctrl_q[ch].bypass),
      .wr_prd  (wr_prd),
      .wdata   (wdata),
      .wmask   (wmask),
      .pwm_o   (pwm_o[ch]),
      .ready_o (ready[ch]),
      .shadow_o(shadow[ch])
    );
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (word == '0) begin
        for (int i = 0; i < NCH; i++) begin
          rdata[FIELD_STRIDE*i +: CTRL_W] = ctrl_q[i];
          rdata[RDY_BASE + i]             = ready[i];
        end
      end else begin
        for (int i = 0; i < NCH; i++)
          if (word == WORD_W'(i + 1)) rdata = shadow[i];
      end
    end
  end

endmodule

// File: tb/pwm2_ctrl_tb_top.sv
module pwm2_ctrl_tb_top;

  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic [31:0] rdata;
  logic [1:0]  pwm;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pwm2_ctrl #(.NCH(NCH), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .pwm_o(pwm)
  );

  // ---------------- behavioural reference ----------------
  logic [9:0]  m_ctrl [NCH];
  logic [31:0] m_sh   [NCH];
  int          m_prd  [NCH];
  int          m_duty [NCH];
  int          m_pos  [NCH];
  bit          m_pend [NCH];

  function automatic int divof(input logic [3:0] c);
    case (c)
      0: return 120;    1: return 180;    2: return 240;
      3: return 360;    4: return 480;    8: return 12000;
      9: return 24000;  10: return 36000; 11: return 48000;
      12: return 72000; 15: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_run(input int ch);
    return m_ctrl[ch][4] && m_ctrl[ch][6] && divof(m_ctrl[ch][3:0]) != 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int ch = 0; ch < NCH; ch++) begin
        m_ctrl[ch] = '0; m_sh[ch] = '0; m_prd[ch] = 0;
        m_duty[ch] = 0; m_pos[ch] = 0; m_pend[ch] = 0;
      end
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        bit take;
        take = 0;
        if (!m_run(ch)) begin
          m_pos[ch] = 0;
          take = m_pend[ch];
        end else begin
          m_pos[ch]++;
          if (m_pos[ch] == (m_prd[ch] + 1) * divof(m_ctrl[ch][3:0])) begin
            m_pos[ch] = 0;
            take = m_pend[ch];
          end
        end
        if (take) begin
          m_prd[ch]  = int'(m_sh[ch][31:16]);
          m_duty[ch] = int'(m_sh[ch][15:0]);
          m_pend[ch] = 0;
        end
      end
      if (wr_en && addr[1:0] == 2'b00) begin
        logic [31:0] mk;
        for (int b = 0; b < 4; b++) mk[8*b +: 8] = {8{wstrb[b]}};
        if (addr[3:2] == 0) begin
          for (int ch = 0; ch < NCH; ch++)
            m_ctrl[ch] = (m_ctrl[ch] & ~mk[15*ch +: 10]) | (wdata[15*ch +: 10] & mk[15*ch +: 10]);
        end else if (int'(addr[3:2]) <= NCH) begin
          m_sh[addr[3:2]-1]   = (m_sh[addr[3:2]-1] & ~mk) | (wdata & mk);
          m_pend[addr[3:2]-1] = 1;
        end
      end
    end
  end

  function automatic logic exp_pwm(input int ch);
    bit on;
    if (m_ctrl[ch][9]) return clk;
    on = m_run(ch) && (m_pos[ch] / divof(m_ctrl[ch][3:0]) < m_duty[ch]);
    return m_ctrl[ch][5] ? on : !on;
  endfunction

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r;
    r = '0;
    if (addr[1:0] != 2'b00) return r;
    if (addr[3:2] == 0) begin
      for (int ch = 0; ch < NCH; ch++) begin
        r[15*ch +: 10] = m_ctrl[ch];
        r[28 + ch]     = !m_pend[ch];
      end
    end else if (int'(addr[3:2]) <= NCH) r = m_sh[addr[3:2]-1];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // per-clock comparison, half a period after each rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [31:0] er;
      for (int ch = 0; ch < NCH; ch++) begin
        string tag;
        if (m_ctrl[ch][9])                       tag = "R9";
        else if (divof(m_ctrl[ch][3:0]) == 0)    tag = "R3";
        else if (!m_run(ch))                     tag = "R7";
        else                                     tag = "R5";
        chk(pwm[ch] === exp_pwm(ch), tag, 32'(pwm[ch]), 32'(exp_pwm(ch)));
      end
      er = exp_rdata();
      chk(rdata === er, (addr == 0 && rdata[27:0] === er[27:0]) ? "R8" : "R1", rdata, er);
    end
  end

  // ---------------- stimulus ----------------
  logic [9:0] b0 = '0, b1 = '0;

  function automatic logic [9:0] ctl(input logic [3:0] c, input bit en, input bit ah,
                                      input bit run, input bit byp);
    return {byp, 2'b00, run, ah, en, c};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    @(posedge clk); #2;
    wr_en = 1; addr = a; wdata = d; wstrb = s;
    @(posedge clk); #2;
    wr_en = 0; wstrb = '0; addr = '0;
  endtask

  task automatic wr_ctrl();
    wr(4'h0, (32'(b1) << 15) | 32'(b0), 4'hF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk); #1;
    chk(rdata === 32'h3000_0000, "R1", rdata, 32'h3000_0000);  // reset: fields 0, both ready
    chk(pwm === 2'b11, "R6", 32'(pwm), 32'h3);                  // act bit 0 -> inactive is 1

    wr(4'h4, {16'd4, 16'd2}, 4'hF);                             // R8: stopped -> taken next clock
    idle(2); #2;
    chk(rdata[28] === 1'b1, "R8", 32'(rdata[28]), 32'h1);
    b0 = ctl(4'd15, 1, 1, 1, 0); wr_ctrl(); idle(30);           // R5 basic run

    @(posedge clk); #2; wr_en = 1; addr = 4'h4; wdata = {16'd4, 16'd4}; wstrb = 4'hF;
    @(posedge clk); #2; wr_en = 0; addr = 4'h0;
    @(negedge clk); #1;
    chk(rdata[28] === 1'b0, "R8", 32'(rdata[28]), 32'h0);       // pending until boundary
    idle(20);
    wr(4'h4, {16'd4, 16'd0}, 4'hF); idle(20);                   // R5 duty 0
    wr(4'h4, {16'd4, 16'd7}, 4'hF); idle(20);                   // R5 duty above period
    wr(4'h4, {16'd3, 16'd1}, 4'hF); idle(20);
    b0 = ctl(4'd15, 1, 0, 1, 0); wr_ctrl(); idle(15);           // R6 inverted

    wr(4'h8, {16'd1, 16'd1}, 4'hF);
    b1 = ctl(4'd0, 1, 1, 1, 0); wr_ctrl();
    begin : r4_measure                                          // R4: step of 120 cycles
      int hi; int guard;
      hi = 0; guard = 0;
      @(negedge clk); #1;
      while (pwm[1] !== 1'b0 && guard < 600) begin @(negedge clk); #1; guard++; end
      while (pwm[1] !== 1'b1 && guard < 600) begin @(negedge clk); #1; guard++; end
      while (pwm[1] === 1'b1 && guard < 600) begin hi++; @(negedge clk); #1; guard++; end
      chk(hi == 120, "R4", 32'(hi), 32'd120);
    end

    b0 = ctl(4'd15, 1, 1, 0, 0); wr_ctrl(); idle(10);           // R7 clock-run off
    b0 = ctl(4'd15, 0, 1, 1, 0); wr_ctrl(); idle(10);           // R7 enable off
    b0 = ctl(4'd5, 1, 1, 1, 0);  wr_ctrl(); idle(10);           // R3 invalid code
    b0 = ctl(4'd13, 1, 1, 1, 0); wr_ctrl(); idle(10);           // R3 invalid code
    b0 = ctl(4'd2, 0, 1, 1, 1);  wr_ctrl(); idle(3);            // R9 bypass, enable off
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk(pwm[0] === 1'b1, "R9", 32'(pwm[0]), 32'h1);
    end
    b0 = ctl(4'd15, 1, 1, 1, 0); wr_ctrl(); idle(10);

    b1 = ctl(4'd0, 1, 0, 1, 0);                                 // R2: upper bytes only
    wr(4'h0, (32'(b1) << 15) | 32'h0000_FFFF, 4'b1100);
    @(negedge clk); #1;
    chk(rdata[9:0] === b0, "R2", 32'(rdata[9:0]), 32'(b0));
    chk(rdata[24:15] === b1, "R2", 32'(rdata[24:15]), 32'(b1));
    idle(20);

    b1 = '0; wr_ctrl();
    wr(4'h8, {16'd1, 16'd1}, 4'hF);
    b1 = ctl(4'd8, 1, 1, 1, 0); wr_ctrl(); idle(25000);         // R3 divide by 12000

    @(posedge clk); #2; addr = 4'hC;                            // R1 unmapped word
    @(negedge clk); #1; chk(rdata === 32'h0, "R1", rdata, 32'h0);
    @(posedge clk); #2; addr = 4'h6;                            // R1 unaligned read
    @(negedge clk); #1; chk(rdata === 32'h0, "R1", rdata, 32'h0);
    wr(4'h5, 32'hFFFF_FFFF, 4'hF);                              // R1 unaligned write dropped
    @(posedge clk); #2; addr = 4'h4;
    @(negedge clk); #1; chk(rdata === {16'd3, 16'd1}, "R1", rdata, {16'd3, 16'd1});
    idle(5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule